// File: doc/BRIEF.md
# Hardware Thread Activation Scheduler

This block keeps the run state of a small, fixed set of hardware thread contexts. It holds three ordered lists of thread numbers. The running list holds the threads that may issue. Its head is the thread with the highest priority. The waiting list holds threads that were asked to run but were held back by the threading policy. The parked list holds suspended threads. Each list keeps the order in which threads were added, and no thread number appears twice in one list.

Each cycle the block accepts one thread command (activate, deactivate, deallocate or suspend) together with a thread number. A separate request, which has lower priority, promotes the oldest waiting thread. A policy input selects how activation behaves:

- Single-thread: only thread 0 may run.
- Simultaneous multithreading: any thread may run.
- Switch-on-miss: a second thread is kept waiting while one thread is already running.

Whenever more than one thread is running, the block rotates the running list at the end of the cycle. This gives the threads round-robin priority. The outputs are the running list, its length, a mask for each of the three lists, a wake pulse and a clear-stalls pulse for each thread. A pipeline around the block uses these outputs to pick threads and release their stalls.

Top module: `threadActivationScheduler`

## Requirements
- R1: While reset is low, and on the first cycle after reset, all three lists are empty. Every mask, the running count, every running-list slot, `wakePulse` and `clearStall` are zero.
- R2: An activate of a thread that is not running, when the policy does not hold it back, has three effects. It appends the thread to the tail of the running list. It removes the thread from the parked list. It raises `wakePulse` for one cycle. An activate of a thread that is already running still removes it from the parked list, but changes nothing else and gives no wake.
- R3: Policy 2 (`mode` = 2'd2) is switch-on-miss. In this policy, activating a thread that is not running while exactly one thread runs appends the thread to the tail of the waiting list. It gives no wake. With zero running threads, the thread runs as in R2.
- R4: `nextReq` removes the head of the waiting list and then activates that thread by the rules of R2, R3 and R11. When the waiting list is empty, `nextReq` has no effect.
- R5: When a thread command and `nextReq` arrive in the same cycle, the thread command is applied first. The waiting-list head and the running count that the promotion sees are the values after that command.
- R6: Command encodings are 2'd1 for deactivate and 2'd2 for deallocate. Both remove the thread from the running list. If the thread was running, `clearStall` shows a one-hot pulse on that thread's bit. If no promotion follows in the same cycle, the thread is not running afterwards.
- R7: Suspend (`cmdOp` = 2'd3) first does a deactivate and then appends the thread to the tail of the parked list.
- R8: At the end of every cycle in which more than one thread is running, after all commands are applied, the head of the running list moves to its tail.
- R9: Appending a thread that is already in a list does nothing, so no list ever holds a duplicate.
- R10: A command with `cmdTid` at or above the thread count has no effect.
- R11: In policy 0 (single-thread), an activate of any thread other than 0 is ignored entirely, and the thread is not even removed from the parked list. A promotion in policy 0 still removes its head from the waiting list. Policies 1 and 3 both select simultaneous multithreading.
- R12: All outputs are registered, so the effect of a command shows on the outputs one cycle after the clock edge that samples it. Running-list slots at or beyond the running count read as zero, and slot 0 (the lowest bits) is the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Policy: 0 single-thread, 1 or 3 multithreaded, 2 switch-on-miss |
| cmdValid | input | 1 | A thread command is present this cycle |
| cmdOp | input | 2 | 0 activate, 1 deactivate, 2 deallocate, 3 suspend |
| cmdTid | input | TID_W (3) | Thread number of the command |
| nextReq | input | 1 | Promote the head of the waiting list |
| activeMask | output | NUM_THREADS (4) | One bit per running thread |
| activeList | output | NUM_THREADS*TID_W (12) | Running list, head in slot 0 |
| activeCount | output | CNT_W (3) | Number of running threads |
| readyMask | output | NUM_THREADS (4) | One bit per waiting thread |
| suspendMask | output | NUM_THREADS (4) | One bit per parked thread |
| wakePulse | output | 1 | A thread joined the running list |
| clearStall | output | NUM_THREADS (4) | One-hot: release the stalls of the thread just removed |

## Verification
Assertions placed next to the logic check several rules on every cycle:

- No list holds a duplicate.
- A bare rotation moves the second entry to the head.
- Every newly running thread comes with a wake pulse.
- Single-thread policy never starts a thread other than 0.
- Deactivate and suspend leave the thread stopped or parked.
- Out-of-range commands change nothing.

Only the bench scenarios can show the exact ordering of the lists. This covers the tail position of appended threads, the ordering of a same-cycle command and promotion, and a promotion being diverted back to the waiting list under switch-on-miss. The bench checks these against a queue model across long mixed command sweeps in all four policy codes.

// File: rtl/threadSchedPkg.sv
package threadSchedPkg;

  typedef enum logic [1:0] {
    OP_ACTIVATE   = 2'd0,
    OP_DEACTIVATE = 2'd1,
    OP_DEALLOCATE = 2'd2,
    OP_SUSPEND    = 2'd3
  } schedOp_e;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'd0,
    MODE_SMT     = 2'd1,
    MODE_SWITCH  = 2'd2,
    MODE_SMT_ALT = 2'd3
  } schedMode_e;

  // Edit strobes, applied by the queue datapath in field order:
  // stage 1 is the thread command, stage 2 the promotion, then rotation.
  typedef struct packed {
    logic rmSusp1;
    logic rmAct1;
    logic appAct1;
    logic appRdy1;
    logic appSusp1;
    logic clrStall;
    logic pop2;
    logic rmSusp2;
    logic appAct2;
    logic appRdy2;
    logic rotate;
    logic wake;
  } schedStrobes_t;

endpackage

// File: rtl/threadSchedCtrl.sv
module threadSchedCtrl
  import threadSchedPkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 3,
  parameter int CNT_W       = 3
) (
  input  logic [1:0]             mode,
  input  logic                   cmdValid,
  input  logic [1:0]             cmdOp,
  input  logic [TID_W-1:0]       cmdTid,
  input  logic                   nextReq,
  input  logic [NUM_THREADS-1:0] actMask,
  input  logic [CNT_W-1:0]       actCount,
  input  logic [CNT_W-1:0]       rdyCount,
  input  logic [TID_W-1:0]       rdyHead,
  output schedStrobes_t          strb
);

  schedMode_e modeE;
  schedOp_e   opE;
  assign modeE = schedMode_e'(mode);
  assign opE   = schedOp_e'(cmdOp);

  function automatic logic maskBit(input logic [NUM_THREADS-1:0] m,
                                   input logic [TID_W-1:0] t);
    logic b;
    b = 1'b0;
    for (int j = 0; j < NUM_THREADS; j++)
      if (t == TID_W'(j)) b = m[j];
    return b;
  endfunction

  logic                   tidOk;
  logic                   isRunning;
  logic                   singleMode;
  logic                   switchMode;
  logic [NUM_THREADS-1:0] mask1;
  logic [CNT_W-1:0]       count1;
  logic [CNT_W-1:0]       count2;
  logic [TID_W-1:0]       head1;
  logic                   rdyAny;

  assign singleMode = (modeE == MODE_SINGLE);
  assign switchMode = (modeE == MODE_SWITCH);
  assign tidOk      = cmdValid && (cmdTid < TID_W'(NUM_THREADS));
  assign isRunning  = tidOk && maskBit(actMask, cmdTid);

  always_comb begin
    strb = '0;
    // stage 1: the thread command
    if (tidOk) begin
      if (opE == OP_ACTIVATE) begin
        if (!(singleMode && cmdTid != '0)) begin
          strb.rmSusp1 = 1'b1;
          if (!isRunning) begin
            if (switchMode && actCount == CNT_W'(1)) strb.appRdy1 = 1'b1;
            else                                      strb.appAct1 = 1'b1;
          end
        end
      end else begin
        strb.rmAct1   = isRunning;
        strb.clrStall = isRunning;
        strb.appSusp1 = (opE == OP_SUSPEND);
      end
    end

    // running state as seen after stage 1
    mask1 = actMask;
    for (int j = 0; j < NUM_THREADS; j++) begin
      if (cmdTid == TID_W'(j) && strb.appAct1) mask1[j] = 1'b1;
      if (cmdTid == TID_W'(j) && strb.rmAct1)  mask1[j] = 1'b0;
    end
    count1 = actCount + CNT_W'(strb.appAct1) - CNT_W'(strb.rmAct1);
    rdyAny = (rdyCount != '0) || strb.appRdy1;
    head1  = (rdyCount != '0) ? rdyHead : cmdTid;

    // stage 2: promotion of the waiting head, lower priority
    if (nextReq && rdyAny) begin
      strb.pop2 = 1'b1;
      if (!(singleMode && head1 != '0)) begin
        strb.rmSusp2 = 1'b1;
        if (!maskBit(mask1, head1)) begin
          if (switchMode && count1 == CNT_W'(1)) strb.appRdy2 = 1'b1;
          else                                    strb.appAct2 = 1'b1;
        end
      end
    end

    count2      = count1 + CNT_W'(strb.appAct2);
    strb.rotate = (count2 > CNT_W'(1));
    strb.wake   = strb.appAct1 | strb.appAct2;
  end

endmodule

// File: rtl/threadSchedQueues.sv
module threadSchedQueues
  import threadSchedPkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 3,
  parameter int CNT_W       = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  schedStrobes_t                strb,
  input  logic [TID_W-1:0]             cmdTid,
  output logic [NUM_THREADS*TID_W-1:0] actListFlat,
  output logic [CNT_W-1:0]             actCount,
  output logic [NUM_THREADS-1:0]       actMask,
  output logic [NUM_THREADS-1:0]       rdyMask,
  output logic [NUM_THREADS-1:0]       susMask,
  output logic [CNT_W-1:0]             rdyCount,
  output logic [TID_W-1:0]             rdyHead,
  output logic                         wakePulse,
  output logic [NUM_THREADS-1:0]       clearStall
);

  typedef logic [NUM_THREADS-1:0][TID_W-1:0] list_t;
  typedef struct packed {
    list_t            l;
    logic [CNT_W-1:0] c;
  } q_t;

  function automatic logic qHas(input q_t q, input logic [TID_W-1:0] t);
    logic h;
    h = 1'b0;
    for (int i = 0; i < NUM_THREADS; i++)
      if (CNT_W'(i) < q.c && q.l[i] == t) h = 1'b1;
    return h;
  endfunction

  function automatic q_t qAdd(input q_t q, input logic [TID_W-1:0] t);
    q_t r;
    r = q;
    if (!qHas(q, t) && q.c < CNT_W'(NUM_THREADS)) begin
      for (int i = 0; i < NUM_THREADS; i++)
        if (CNT_W'(i) == q.c) r.l[i] = t;
      r.c = q.c + CNT_W'(1);
    end
    return r;
  endfunction

  function automatic q_t qDel(input q_t q, input logic [TID_W-1:0] t);
    q_t   r;
    logic hit;
    r   = q;
    hit = 1'b0;
    for (int i = 0; i < NUM_THREADS - 1; i++) begin
      if (!hit && CNT_W'(i) < q.c && q.l[i] == t) hit = 1'b1;
      if (hit) r.l[i] = q.l[i+1];
    end
    if (!hit && q.c == CNT_W'(NUM_THREADS) && q.l[NUM_THREADS-1] == t) hit = 1'b1;
    if (hit) begin
      r.l[NUM_THREADS-1] = '0;
      r.c = q.c - CNT_W'(1);
    end
    return r;
  endfunction

  function automatic q_t qRot(input q_t q);
    q_t r;
    r = q;
    for (int i = 0; i < NUM_THREADS - 1; i++)
      if (CNT_W'(i + 1) < q.c) r.l[i] = q.l[i+1];
    for (int i = 0; i < NUM_THREADS; i++)
      if (CNT_W'(i) == q.c - CNT_W'(1)) r.l[i] = q.l[0];
    return r;
  endfunction

  q_t actQ, rdyQ, susQ;
  q_t actN, rdyN, susN;
  logic [TID_W-1:0]       promoteTid;
  logic [NUM_THREADS-1:0] clrN;
  logic                   wakeQ;
  logic [NUM_THREADS-1:0] clrQ;

  always_comb begin
    actN = actQ;
    rdyN = rdyQ;
    susN = susQ;
    if (strb.rmSusp1)  susN = qDel(susN, cmdTid);
    if (strb.rmAct1)   actN = qDel(actN, cmdTid);
    if (strb.appAct1)  actN = qAdd(actN, cmdTid);
    if (strb.appRdy1)  rdyN = qAdd(rdyN, cmdTid);
    if (strb.appSusp1) susN = qAdd(susN, cmdTid);
    promoteTid = rdyN.l[0];
    if (strb.pop2)     rdyN = qDel(rdyN, promoteTid);
    if (strb.rmSusp2)  susN = qDel(susN, promoteTid);
    if (strb.appRdy2)  rdyN = qAdd(rdyN, promoteTid);
    if (strb.appAct2)  actN = qAdd(actN, promoteTid);
    if (strb.rotate)   actN = qRot(actN);
  end

  always_comb begin
    clrN = '0;
    for (int j = 0; j < NUM_THREADS; j++)
      if (strb.clrStall && cmdTid == TID_W'(j)) clrN[j] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actQ  <= '0;
      rdyQ  <= '0;
      susQ  <= '0;
      wakeQ <= 1'b0;
      clrQ  <= '0;
    end else begin
      actQ  <= actN;
      rdyQ  <= rdyN;
      susQ  <= susN;
      wakeQ <= strb.wake;
      clrQ  <= clrN;
    end
  end

  always_comb begin
    for (int j = 0; j < NUM_THREADS; j++) begin
      actMask[j] = qHas(actQ, TID_W'(j));
      rdyMask[j] = qHas(rdyQ, TID_W'(j));
      susMask[j] = qHas(susQ, TID_W'(j));
    end
  end

  assign actListFlat = actQ.l;
  assign actCount    = actQ.c;
  assign rdyCount    = rdyQ.c;
  assign rdyHead     = rdyQ.l[0];
  assign wakePulse   = wakeQ;
  assign clearStall  = clrQ;

  logic onlyRotate;
  assign onlyRotate = strb.rotate && !(strb.rmSusp1 || strb.rmAct1 || strb.appAct1 ||
                      strb.appRdy1 || strb.appSusp1 || strb.pop2 || strb.rmSusp2 ||
                      strb.appAct2 || strb.appRdy2);

  // R9: each list length matches its count of distinct members
  a_r9_no_duplicates: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(actMask) == int'(actQ.c)) && ($countones(rdyMask) == int'(rdyQ.c)) &&
    ($countones(susMask) == int'(susQ.c)));

  // R8: a cycle with no edits moves the second running entry to the head
  a_r8_rotate_head: assert property (@(posedge clk) disable iff (!rstN)
    onlyRotate |=> (actQ.l[0] == $past(actQ.l[1])) && (actQ.c == $past(actQ.c)));

  // R2: a wake pulse implies at least one running thread
  a_r2_wake_has_runner: assert property (@(posedge clk) disable iff (!rstN)
    wakeQ |-> (actQ.c != '0));

  // R6: clear-stall pulses name at most one thread
  a_r6_clear_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clrQ));

endmodule

// File: rtl/threadActivationScheduler.sv
module threadActivationScheduler
  import threadSchedPkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TID_W      = $clog2(NUM_THREADS) + 1,
  localparam int CNT_W      = $clog2(NUM_THREADS + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   mode,
  input  logic                         cmdValid,
  input  logic [1:0]                   cmdOp,
  input  logic [TID_W-1:0]             cmdTid,
  input  logic                         nextReq,
  output logic [NUM_THREADS-1:0]       activeMask,
  output logic [NUM_THREADS*TID_W-1:0] activeList,
  output logic [CNT_W-1:0]             activeCount,
  output logic [NUM_THREADS-1:0]       readyMask,
  output logic [NUM_THREADS-1:0]       suspendMask,
  output logic                         wakePulse,
  output logic [NUM_THREADS-1:0]       clearStall
);

  schedStrobes_t    strb;
  logic [CNT_W-1:0] rdyCount;
  logic [TID_W-1:0] rdyHead;

  threadSchedCtrl #(
    .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .mode(mode), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdTid(cmdTid),
    .nextReq(nextReq), .actMask(activeMask), .actCount(activeCount),
    .rdyCount(rdyCount), .rdyHead(rdyHead), .strb(strb)
  );

  threadSchedQueues #(
    .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .CNT_W(CNT_W)
  ) queues_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdTid(cmdTid),
    .actListFlat(activeList), .actCount(activeCount), .actMask(activeMask),
    .rdyMask(readyMask), .susMask(suspendMask), .rdyCount(rdyCount),
    .rdyHead(rdyHead), .wakePulse(wakePulse), .clearStall(clearStall)
  );

  // R2: any thread newly in the running mask comes with a wake pulse
  a_r2_new_runner_wakes: assert property (@(posedge clk) disable iff (!rstN)
    ((activeMask & ~$past(activeMask)) != '0) |-> wakePulse);

  // R11: in single-thread policy no thread other than 0 starts running
  a_r11_single_only_zero: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |=> (((activeMask & ~$past(activeMask)) >> 1) == '0));

  // R6: a deactivate, deallocate or suspend leaves the thread stopped
  a_r6_stopped_after: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp != 2'd0 && cmdTid < TID_W'(NUM_THREADS) && !nextReq) |=>
    (((activeMask >> $past(cmdTid)) & NUM_THREADS'(1)) == '0));

  // R7: a suspend leaves the thread parked
  a_r7_parked_after: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd3 && cmdTid < TID_W'(NUM_THREADS) && !nextReq) |=>
    (((suspendMask >> $past(cmdTid)) & NUM_THREADS'(1)) != '0));

  // R10: out-of-range thread numbers change no list and raise no pulse
  a_r10_range_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdTid >= TID_W'(NUM_THREADS) && !nextReq) |=>
    ($stable(activeMask) && $stable(readyMask) && $stable(suspendMask) &&
     !wakePulse && clearStall == '0));

endmodule

// File: tb/threadActivationScheduler_tb.sv
`timescale 1ns/1ps
module threadActivationScheduler_tb_top;

  localparam int N  = 4;
  localparam int TW = 3;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    mode = 2'd1;
  logic          cmdValid = 1'b0;
  logic [1:0]    cmdOp = 2'd0;
  logic [TW-1:0] cmdTid = '0;
  logic          nextReq = 1'b0;
  logic [N-1:0]    activeMask;
  logic [N*TW-1:0] activeList;
  logic [CW-1:0]   activeCount;
  logic [N-1:0]    readyMask;
  logic [N-1:0]    suspendMask;
  logic            wakePulse;
  logic [N-1:0]    clearStall;

  always #10 clk = ~clk;

  threadActivationScheduler #(.NUM_THREADS(N)) dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdTid(cmdTid), .nextReq(nextReq), .activeMask(activeMask),
    .activeList(activeList), .activeCount(activeCount), .readyMask(readyMask),
    .suspendMask(suspendMask), .wakePulse(wakePulse), .clearStall(clearStall)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- queue model built from the requirements ----------------
  typedef int iq_t[$];
  iq_t  mAct, mRdy, mSus;
  bit   expWake;
  int   expClr;

  function automatic bit qHas(iq_t q, int t);
    foreach (q[i]) if (q[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic iq_t qDel(iq_t q, int t);
    iq_t r;
    foreach (q[i]) if (q[i] != t) r.push_back(q[i]);
    return r;
  endfunction

  function automatic iq_t qAdd(iq_t q, int t);
    iq_t r;
    r = q;
    if (!qHas(q, t) && r.size() < N) r.push_back(t);
    return r;
  endfunction

  task automatic modelActivate(input int t);
    if (mode == 2'd0 && t != 0) return;          // R11
    mSus = qDel(mSus, t);                        // R2
    if (qHas(mAct, t)) return;
    if (mode == 2'd2 && mAct.size() == 1) mRdy = qAdd(mRdy, t);   // R3
    else begin mAct = qAdd(mAct, t); expWake = 1'b1; end
  endtask

  task automatic modelStep(input bit v, input int op, input int tid, input bit nx);
    expWake = 1'b0;
    expClr  = 0;
    if (v && tid < N) begin                      // R10
      if (op == 0) modelActivate(tid);
      else begin
        if (qHas(mAct, tid)) begin expClr = 1 << tid; mAct = qDel(mAct, tid); end
        if (op == 3) mSus = qAdd(mSus, tid);     // R7
      end
    end
    if (nx && mRdy.size() > 0) begin             // R4, R5
      int h;
      h = mRdy[0];
      mRdy.delete(0);
      modelActivate(h);
    end
    if (mAct.size() > 1) begin                   // R8
      int h;
      h = mAct[0];
      mAct.delete(0);
      mAct.push_back(h);
    end
  endtask

  function automatic int maskOf(iq_t q);
    int m;
    m = 0;
    foreach (q[i]) m |= (1 << q[i]);
    return m;
  endfunction

  function automatic int listOf(iq_t q);
    int v;
    v = 0;
    foreach (q[i]) v |= (q[i] << (i * TW));
    return v;
  endfunction

  task automatic compareAll(input string tg);
    chk(tg, "activeMask",  int'(activeMask),  maskOf(mAct));
    chk(tg, "activeList",  int'(activeList),  listOf(mAct));
    chk(tg, "activeCount", int'(activeCount), mAct.size());
    chk(tg, "readyMask",   int'(readyMask),   maskOf(mRdy));
    chk(tg, "suspendMask", int'(suspendMask), maskOf(mSus));
    chk(tg, "wakePulse",   int'(wakePulse),   int'(expWake));
    chk(tg, "clearStall",  int'(clearStall),  expClr);
  endtask

  // drive at a falling edge, result visible at the next falling edge (R12)
  task automatic step(input string tg, input bit v, input int op, input int tid, input bit nx);
    cmdValid = v;
    cmdOp    = 2'(op);
    cmdTid   = TW'(tid);
    nextReq  = nx;
    modelStep(v, op, tid, nx);
    @(negedge clk);
    compareAll(tg);
  endtask

  task automatic resetCheck();
    cmdValid = 1'b0; nextReq = 1'b0;
    rstN = 1'b0;
    mAct.delete(); mRdy.delete(); mSus.delete();
    expWake = 1'b0; expClr = 0;
    repeat (2) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    step("R1", 1'b0, 0, 0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    resetCheck();

    // multithreaded policy
    mode = 2'd1;
    step("R2", 1, 0, 1, 0);
    step("R9", 1, 0, 1, 0);          // duplicate activate: no wake, no change
    step("R2", 1, 0, 2, 0);          // two running -> rotation starts
    step("R8", 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0);
    step("R2", 1, 0, 3, 0);
    step("R7", 1, 3, 1, 0);          // suspend running thread 1
    step("R9", 1, 3, 1, 0);          // suspend again: no duplicate
    step("R2", 1, 0, 1, 0);          // reactivate leaves the parked list
    step("R6", 1, 1, 2, 0);          // deactivate
    step("R6", 1, 2, 3, 0);          // deallocate
    step("R6", 1, 1, 2, 0);          // not running: no clear pulse
    step("R10", 1, 0, 5, 0);
    step("R10", 1, 3, 4, 0);
    step("R4", 0, 0, 0, 1);          // empty waiting list: no effect

    // clear running list, then switch-on-miss policy
    step("R6", 1, 1, 0, 0);
    step("R6", 1, 1, 1, 0);
    step("R6", 1, 1, 3, 0);
    mode = 2'd2;
    step("R3", 1, 0, 0, 0);          // none running -> runs
    step("R3", 1, 0, 3, 0);          // one running -> waits
    chk("R3", "readyMask explicit", int'(readyMask), 4'b1000);
    step("R3", 1, 0, 2, 0);
    step("R4", 0, 0, 0, 1);          // promoted head goes back to the tail
    step("R5", 1, 1, 0, 1);          // stop 0 first, then promote thread 2
    chk("R5", "activeMask explicit", int'(activeMask), 4'b0100);
    step("R4", 1, 1, 2, 1);          // stop 2, promote 3
    step("R4", 0, 0, 0, 1);          // waiting list now empty
    step("R5", 1, 0, 1, 1);          // activate 1 with one running -> waits, then promoted
    step("R7", 1, 3, 3, 0);

    // single-thread policy
    mode = 2'd0;
    step("R11", 1, 1, 1, 0);
    step("R11", 1, 0, 2, 0);
    chk("R11", "thread2 running", int'(activeMask[2]), 0);
    step("R11", 1, 0, 3, 0);         // parked 3 stays parked
    step("R11", 1, 0, 0, 0);
    mode = 2'd3;
    step("R11", 1, 0, 2, 0);         // code 3 behaves as multithreaded

    resetCheck();

    // mixed sweep through every policy code
    begin
      logic [31:0] lf;
      lf = 32'h1ACE_B00C;
      for (int cyc = 0; cyc < 6000; cyc++) begin
        if (cyc % 150 == 0) mode = 2'((cyc / 150) % 4);
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        step("R12", lf[3:2] != 2'b00, int'(lf[5:4]), int'(lf[15:8]) % 6,
             lf[7:6] == 2'b00);
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL R12 watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

endmodule